// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of peripheral interrupt lines and a processor core. It takes 32 level-sensitive external request lines, a periodic tick request and a non-maskable request. It masks the external lines with a software enable word and ranks every live source by a programmable 3-bit priority. It then offers a single winner to the core as an exception number, together with the address of the table word that holds that handler's entry point. The table base is a software register. The address is the base plus four times the exception number.

The core takes the offer with a one-cycle acknowledge pulse. It does this after the instruction it is running has retired. The granted source then becomes active. An active source is not offered again until the core signals completion with that exception number. While sources are active, only a strictly more urgent request can be offered, so handlers nest by priority. Stacking of processor state and the fetch of the table word are done outside this block.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the enable word, all priority fields, the tick priority and the table base read as zero, and `irq_req_o` is low.
- R2: External line n is offered only while bit n of the enable word (register address 0) is set. A line that is high while its enable bit is clear produces no request.
- R3: Priority register k (address 8+k) holds line 4k+b in bits [8b+7:8b+5]. Among eligible sources, the lowest numeric priority is offered.
- R4: The tick priority is held in bits [7:5] of address 2. On equal priority, the source with the lower exception number wins, so the tick beats any external line.
- R5: The non-maskable source reports exception number 2, the tick reports 15, and external line n reports 16+n.
- R6: `vec_addr_o` equals the table base (address 1, bits [1:0] forced to zero) plus 4 times `irq_num_o`, using the base at the time the offer was made.
- R7: The non-maskable source outranks every priority value and has no enable bit.
- R8: Once `irq_req_o` is high, `irq_num_o` and `vec_addr_o` do not change until `ack_i` is seen, even if a more urgent request arrives.
- R9: On acknowledge, the offered source becomes active. It is not offered again until `done_i` is pulsed with its exception number. A completion carrying any other number leaves it active.
- R10: While any source is active, a pending source is offered only if its priority is strictly more urgent than the most urgent active one.
- R11: Unimplemented priority bits, the two low base bits and the unmapped addresses 3 to 7 read as zero, and writes to them have no effect.
- R12: With no offer outstanding, `irq_req_o` rises on the first clock edge at which an eligible source is present. After an acknowledge, the next offer appears one edge later at the earliest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Level-sensitive external request lines |
| tick_i | input | 1 | Periodic tick request, level-sensitive |
| nmi_i | input | 1 | Non-maskable request, level-sensitive |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_req_o | output | 1 | Offer pending toward the core |
| irq_num_o | output | 8 | Exception number of the offer |
| vec_addr_o | output | 32 | Address of the table word for the offer |
| ack_i | input | 1 | Core takes the offer |
| done_i | input | 1 | Core finished a handler |
| done_num_i | input | 8 | Exception number of the finished handler |

## Verification
Suppose the active set gets a bit that is wrongly set or never cleared. The effect shows up at the request output: a source stays silent after its completion pulse, or a lower-urgency source gets through during a nested handler. This is seen within a few cycles of the next completion or arrival. A wrong latch in the offer register shows up as a number or address that moves while the request is held, or as a winner that does not match the priority order. The bench compares every acknowledged offer with a model order it builds from the priority rules. It also watches windows in which no request may appear.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int DW       = 32;
  localparam int EXC_W    = 8;
  localparam int EXC_NMI  = 2;
  localparam int EXC_TICK = 15;
  localparam int EXC_EXT0 = 16;
  localparam int REG_EN   = 0;
  localparam int REG_BASE = 1;
  localparam int REG_TICK = 2;

  // source index: 0 = nmi, 1 = tick, 2+n = external n
  function automatic logic [EXC_W-1:0] src_exc(input int unsigned s);
    if (s == 0) return EXC_W'(EXC_NMI);
    if (s == 1) return EXC_W'(EXC_TICK);
    return EXC_W'(s + EXC_EXT0 - 2);
  endfunction
endpackage

// File: rtl/ivc_regs.sv
module ivc_regs
  import ivc_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 3,
  parameter int AW        = 32,
  parameter int REG_AW    = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [REG_AW-1:0]                 addr_i,
  input  logic [DW-1:0]                     wdata_i,
  output logic [DW-1:0]                     rdata_o,
  output logic [NUM_IRQ-1:0]                en_o,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_o,
  output logic [PRIO_BITS-1:0]              tick_prio_o,
  output logic [AW-1:0]                     base_o
);
  localparam int PRIO_BASE = 2 ** (REG_AW - 1);

  logic [NUM_IRQ-1:0]   en_q;
  logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];
  logic [PRIO_BITS-1:0] tick_q;
  logic [AW-1:0]        base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      tick_q <= '0;
      base_q <= '0;
    end else if (we_i) begin
      if (addr_i == REG_AW'(REG_EN))   en_q   <= wdata_i[NUM_IRQ-1:0];
      if (addr_i == REG_AW'(REG_TICK)) tick_q <= wdata_i[7 -: PRIO_BITS];
      if (addr_i == REG_AW'(REG_BASE)) base_q <= {wdata_i[AW-1:2], 2'b00};
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    localparam int RA  = PRIO_BASE + g / 4;
    localparam int MSB = 8 * (g % 4) + 7;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             prio_q[g] <= '0;
      else if (we_i && addr_i == REG_AW'(RA))  prio_q[g] <= wdata_i[MSB -: PRIO_BITS];
    end
    assign prio_o[g] = prio_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_AW'(REG_EN))        rdata_o[NUM_IRQ-1:0] = en_q;
    else if (addr_i == REG_AW'(REG_BASE)) rdata_o[AW-1:0]      = base_q;
    else if (addr_i == REG_AW'(REG_TICK)) rdata_o[7 -: PRIO_BITS] = tick_q;
    else begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (addr_i == REG_AW'(PRIO_BASE + i / 4))
          rdata_o[8 * (i % 4) + 7 -: PRIO_BITS] = prio_q[i];
    end
  end

  assign en_o        = en_q;
  assign tick_prio_o = tick_q;
  assign base_o      = base_q;

  a_r11_base_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_AW'(REG_BASE)) |=> (base_o[1:0] == 2'b00));
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int NSRC  = 34,
  parameter int KW    = 4,
  parameter int SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]         cand_i,
  input  logic [NSRC-1:0][KW-1:0] key_i,
  input  logic [KW-1:0]           run_lvl_i,
  output logic                    win_vld_o,
  output logic [SRC_W-1:0]        win_src_o
);
  logic [KW-1:0] best;

  // strict compare keeps the lowest index on equal keys
  always_comb begin
    win_vld_o = 1'b0;
    win_src_o = '0;
    best      = '1;
    for (int s = 0; s < NSRC; s++) begin
      if (cand_i[s] && key_i[s] < run_lvl_i && (!win_vld_o || key_i[s] < best)) begin
        win_vld_o = 1'b1;
        win_src_o = SRC_W'(s);
        best      = key_i[s];
      end
    end
  end
endmodule

// File: rtl/ivc_active.sv
module ivc_active
  import ivc_pkg::*;
#(
  parameter int NSRC  = 34,
  parameter int KW    = 4,
  parameter int SRC_W = $clog2(NSRC)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    set_i,
  input  logic [SRC_W-1:0]        set_src_i,
  input  logic                    clr_i,
  input  logic [EXC_W-1:0]        clr_exc_i,
  input  logic [NSRC-1:0][KW-1:0] key_i,
  output logic [NSRC-1:0]         active_o,
  output logic [KW-1:0]           run_lvl_o
);
  localparam int NUM_IRQ = NSRC - 2;

  logic [NSRC-1:0]  act_q;
  logic             clr_vld;
  logic [SRC_W-1:0] clr_src;

  always_comb begin
    clr_vld = 1'b0;
    clr_src = '0;
    if (clr_exc_i == EXC_W'(EXC_NMI)) begin
      clr_vld = 1'b1;
      clr_src = SRC_W'(0);
    end else if (clr_exc_i == EXC_W'(EXC_TICK)) begin
      clr_vld = 1'b1;
      clr_src = SRC_W'(1);
    end else if (clr_exc_i >= EXC_W'(EXC_EXT0) &&
                 clr_exc_i < EXC_W'(EXC_EXT0 + NUM_IRQ)) begin
      clr_vld = 1'b1;
      clr_src = SRC_W'(clr_exc_i - EXC_W'(EXC_EXT0 - 2));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else begin
      if (clr_i && clr_vld) act_q[clr_src]   <= 1'b0;
      if (set_i)            act_q[set_src_i] <= 1'b1;
    end
  end

  always_comb begin
    run_lvl_o = '1;
    for (int s = 0; s < NSRC; s++)
      if (act_q[s] && key_i[s] < run_lvl_o) run_lvl_o = key_i[s];
  end

  assign active_o = act_q;

  a_r9_grant_not_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !act_q[set_src_i]);
endmodule

// File: rtl/ivc_offer.sv
module ivc_offer
  import ivc_pkg::*;
#(
  parameter int SRC_W = 6,
  parameter int AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_vld_i,
  input  logic [SRC_W-1:0] win_src_i,
  input  logic [EXC_W-1:0] win_exc_i,
  input  logic [AW-1:0]    base_i,
  input  logic             ack_i,
  output logic             req_o,
  output logic [EXC_W-1:0] num_o,
  output logic [AW-1:0]    addr_o,
  output logic [SRC_W-1:0] src_o,
  output logic             grant_o
);
  logic             req_q;
  logic [EXC_W-1:0] num_q;
  logic [AW-1:0]    addr_q;
  logic [SRC_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      num_q  <= '0;
      addr_q <= '0;
      src_q  <= '0;
    end else if (req_q) begin
      if (ack_i) req_q <= 1'b0;
    end else if (win_vld_i) begin
      req_q  <= 1'b1;
      num_q  <= win_exc_i;
      src_q  <= win_src_i;
      addr_q <= base_i + {{(AW-EXC_W-2){1'b0}}, win_exc_i, 2'b00};
    end
  end

  assign req_o   = req_q;
  assign num_o   = num_q;
  assign addr_o  = addr_q;
  assign src_o   = src_q;
  assign grant_o = req_q & ack_i;

  a_r8_offer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> (req_q && $stable(num_q) && $stable(addr_q)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 3,
  parameter int AW        = 32,
  parameter int REG_AW    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               tick_i,
  input  logic               nmi_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               irq_req_o,
  output logic [EXC_W-1:0]   irq_num_o,
  output logic [AW-1:0]      vec_addr_o,
  input  logic               ack_i,
  input  logic               done_i,
  input  logic [EXC_W-1:0]   done_num_i
);
  localparam int NSRC  = NUM_IRQ + 2;
  localparam int SRC_W = $clog2(NSRC);
  localparam int KW    = PRIO_BITS + 1;

  logic [NUM_IRQ-1:0]                en;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
  logic [PRIO_BITS-1:0]              tick_prio;
  logic [AW-1:0]                     base;
  logic [NSRC-1:0][KW-1:0]           key;
  logic [NSRC-1:0]                   active, cand;
  logic [KW-1:0]                     run_lvl;
  logic                              win_vld, grant;
  logic [SRC_W-1:0]                  win_src, offer_src;
  logic [EXC_W-1:0]                  win_exc;

  ivc_regs #(
    .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .AW(AW), .REG_AW(REG_AW)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .en_o(en), .prio_o(prio), .tick_prio_o(tick_prio), .base_o(base)
  );

  // key 0 reserved for the non-maskable source; programmable levels sit above it
  always_comb begin
    key[0] = '0;
    key[1] = {1'b0, tick_prio} + KW'(1);
    for (int n = 0; n < NUM_IRQ; n++) key[n+2] = {1'b0, prio[n]} + KW'(1);
  end

  assign cand = {irq_i & en, tick_i, nmi_i} & ~active;

  ivc_arbiter #(.NSRC(NSRC), .KW(KW), .SRC_W(SRC_W)) u_arb (
    .cand_i(cand), .key_i(key), .run_lvl_i(run_lvl),
    .win_vld_o(win_vld), .win_src_o(win_src)
  );

  assign win_exc = src_exc(32'(win_src));

  ivc_offer #(.SRC_W(SRC_W), .AW(AW)) u_offer (
    .clk_i, .rst_ni,
    .win_vld_i(win_vld), .win_src_i(win_src), .win_exc_i(win_exc), .base_i(base),
    .ack_i, .req_o(irq_req_o), .num_o(irq_num_o), .addr_o(vec_addr_o),
    .src_o(offer_src), .grant_o(grant)
  );

  ivc_active #(.NSRC(NSRC), .KW(KW), .SRC_W(SRC_W)) u_act (
    .clk_i, .rst_ni,
    .set_i(grant), .set_src_i(offer_src),
    .clr_i(done_i), .clr_exc_i(done_num_i),
    .key_i(key), .active_o(active), .run_lvl_o(run_lvl)
  );

  a_r5_num_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_num_o == EXC_W'(EXC_NMI) || irq_num_o == EXC_W'(EXC_TICK) ||
                   (irq_num_o >= EXC_W'(EXC_EXT0) && irq_num_o < EXC_W'(EXC_EXT0 + NUM_IRQ))));

  a_r7_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !active[0] && !irq_req_o) |=> (irq_req_o && irq_num_o == EXC_W'(EXC_NMI)));

  a_r12_no_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_req_o && win_vld) |=> irq_req_o);
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        tick = 1'b0, nmi = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req_o;
  logic [7:0]  irq_num_o;
  logic [31:0] vec_addr_o;
  logic        ack_i = 1'b0, done = 1'b0;
  logic [7:0]  done_num = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] bbase = '0;

  typedef struct { logic [7:0] num; logic [31:0] addr; string tag; } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  irq_vec_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .tick_i(tick), .nmi_i(nmi),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_req_o, .irq_num_o, .vec_addr_o, .ack_i,
    .done_i(done), .done_num_i(done_num)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic reg_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1 addr = a; #2;
    chk(tag, rdata, exp);
  endtask

  task automatic push(input logic [7:0] num, input string tag);
    item_t it;
    it.num = num; it.addr = bbase + 32'(num) * 4; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq_req_o) break;
    end
    chk("R12 request appears", {31'b0, irq_req_o}, 32'd1);
  endtask

  task automatic serve();
    wait_req();
    @(posedge clk); #1 ack_i = 1'b1;
    @(posedge clk); #1 ack_i = 1'b0;
  endtask

  task automatic finish_irq(input logic [7:0] num);
    @(posedge clk); #1 done = 1'b1; done_num = num;
    @(posedge clk); #1 done = 1'b0;
  endtask

  task automatic idle_chk(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_req_o) seen = 1'b1;
    end
    chk(tag, {31'b0, seen}, 32'd0);
  endtask

  // monitor: every taken offer is compared against the model order
  always @(negedge clk) begin
    if (ack_i && irq_req_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected offer actual=%0d expected=none", irq_num_o);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk({it.tag, " num"}, {24'b0, irq_num_o}, {24'b0, it.num});
        chk({it.tag, " R6 addr"}, vec_addr_o, it.addr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    reg_chk(4'd0, 32'h0, "R1 enable");
    reg_chk(4'd1, 32'h0, "R1 base");
    reg_chk(4'd2, 32'h0, "R1 tick prio");
    reg_chk(4'd8, 32'h0, "R1 prio0");
    chk("R1 no request", {31'b0, irq_req_o}, 32'd0);

    // R11 readback masking
    reg_wr(4'd15, 32'hFFFF_FFFF);
    reg_chk(4'd15, 32'hE0E0_E0E0, "R11 prio low bits");
    reg_wr(4'd3, 32'hFFFF_FFFF);
    reg_chk(4'd3, 32'h0, "R11 unmapped");
    reg_wr(4'd1, 32'h2000_0003);
    bbase = 32'h2000_0000;
    reg_chk(4'd1, 32'h2000_0000, "R11 base low bits");

    // R2 masking, R12 latency, R5/R6 numbering
    irq[30] = 1'b1;
    idle_chk(4, "R2 disabled line silent");
    reg_wr(4'd15, 32'h00A0_0000);
    reg_chk(4'd15, 32'h00A0_0000, "R3 prio field");
    reg_wr(4'd0, 32'h4000_0000);
    @(negedge clk); chk("R12 not before edge", {31'b0, irq_req_o}, 32'd0);
    @(negedge clk); chk("R12 one edge later", {31'b0, irq_req_o}, 32'd1);
    push(8'd46, "R5 line30");
    serve();
    idle_chk(4, "R9 active not reoffered");
    irq[30] = 1'b0;
    finish_irq(8'd46);
    idle_chk(3, "R9 line low after done");

    // R3/R4 priority and ties, R10 blocking
    reg_wr(4'd8, 32'h0000_60C0);
    reg_wr(4'd9, 32'h0000_6000);
    reg_wr(4'd0, 32'h0000_0023);
    irq[0] = 1'b1; irq[1] = 1'b1; irq[5] = 1'b1;
    push(8'd17, "R3 lowest value wins");
    serve();
    idle_chk(4, "R10 equal level blocked");
    irq[1] = 1'b0;
    finish_irq(8'd17);
    push(8'd21, "R4 next by level");
    serve();
    irq[5] = 1'b0;
    finish_irq(8'd21);
    push(8'd16, "R3 lowest urgency last");
    serve();

    // R10 nesting with tick; R9 wrong done number ignored
    reg_wr(4'd2, 32'h0000_0040);
    reg_chk(4'd2, 32'h0000_0040, "R4 tick prio field");
    tick = 1'b1;
    push(8'd15, "R10 more urgent nests");
    serve();
    tick = 1'b0;
    finish_irq(8'd15);
    finish_irq(8'd20);
    idle_chk(4, "R9 wrong done ignored");
    push(8'd16, "R9 reoffer after done");
    finish_irq(8'd16);
    serve();
    irq[0] = 1'b0;
    finish_irq(8'd16);

    // R4 tick vs external tie
    reg_wr(4'd2, 32'h0000_0060);
    tick = 1'b1; irq[1] = 1'b1;
    push(8'd15, "R4 tick wins tie");
    serve();
    tick = 1'b0;
    finish_irq(8'd15);
    push(8'd17, "R4 then line1");
    serve();
    irq[1] = 1'b0;
    finish_irq(8'd17);

    // R8 hold while offered
    irq[0] = 1'b1;
    wait_req();
    chk("R8 first offer", {24'b0, irq_num_o}, 32'd16);
    irq[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 num held", {24'b0, irq_num_o}, 32'd16);
    chk("R8 addr held", vec_addr_o, bbase + 32'd64);
    push(8'd16, "R8 held offer taken");
    serve();
    push(8'd17, "R10 urgent after hold");
    serve();
    irq[1] = 1'b0;
    finish_irq(8'd17);
    irq[0] = 1'b0;
    finish_irq(8'd16);

    // R7 non-maskable over level zero
    reg_wr(4'd8, 32'h0000_00C0);
    reg_wr(4'd0, 32'h0000_0002);
    irq[1] = 1'b1;
    push(8'd17, "R7 level zero line");
    serve();
    nmi = 1'b1;
    push(8'd2, "R7 nmi preempts");
    serve();
    nmi = 1'b0;
    finish_irq(8'd2);
    irq[1] = 1'b0;
    finish_irq(8'd17);

    // R6 new base, top line
    reg_wr(4'd1, 32'h1000_0400);
    bbase = 32'h1000_0400;
    reg_chk(4'd1, 32'h1000_0400, "R6 base readback");
    reg_wr(4'd15, 32'hE000_0000);
    reg_wr(4'd0, 32'h8000_0000);
    irq[31] = 1'b1;
    push(8'd47, "R6 line31");
    serve();
    irq[31] = 1'b0;
    finish_irq(8'd47);

    repeat (3) @(negedge clk);
    chk("R9 all served", 32'(exp_q.size()), 32'd0);
    chk("R1 idle at end", {31'b0, irq_req_o}, 32'd0);
    report();
  end
endmodule